// File: doc/BRIEF.md
# Source-Snoop Request Transaction Tracker

This block follows a single coherence transaction for one cache line, from the side of the node that wants the line. When it accepts a request, it sends one broadcast pulse. The pulse is either a shared read or a read for ownership, and it goes to every other node, the home node included. The block then gathers one snoop response from each peer that is not the home. While it waits, it records in a bitmap every node that competes for the same line.

Once the last required response is in, the block sends the home a second-phase message. That message is a cancel if a peer supplied the data, or a read if no peer did, and it always carries the conflict bitmap. The data can be used as soon as it arrives. The line becomes globally observed only when the home's completion comes back. After that completion the block does three things, as needed:

- It acknowledges the node that supplied the data.
- It waits for the data from a node the home names.
- It forwards the line to a node the home names, once the local consumer reports that it has finished using the line.

The block handles one transaction at a time.

Top module: `sst_tracker`

## Requirements
- R1: A request is accepted only while `req_ready` is high. `req_ready` is low from the cycle after acceptance until the transaction ends, and a request raised during that time produces no broadcast.
- R2: In the cycle after acceptance, `snp_valid` pulses for one cycle, and `snp_rfo` equals the accepted `req_rfo` (0 = shared read, 1 = read for ownership).
- R3: `ph2_valid` pulses exactly once, one cycle after a response has been counted from every node other than this node and the home. A response whose source is the home, or that repeats a source already counted, is not counted.
- R4: `ph2_cancel` is 1 if and only if a counted response had `resp_data` set. Bit n of `ph2_conflicts` is set if, between acceptance and the last counted response (that cycle included), node n either raised `peer_req_valid` or returned a counted response with `resp_kind` = 2 (conflict). A peer request seen while idle is not recorded.
- R5: `line_state` uses the encoding I=0, S=1, E=2, F=3, M=4, and the line is installed as follows:
  - Shared read, peer data: F.
  - Shared read, home data, every response an invalid acknowledgement (`resp_kind` = 0): E.
  - Shared read, home data, at least one shared acknowledgement (`resp_kind` = 1): F.
  - Read for ownership, from any source: M.
- R6: `data_ready` rises when the data arrives, which can be before the home completes. `global_obs` is 0 from acceptance, stays 0 through the second phase, and rises only in the cycle after `home_valid`.
- R7: `dack_valid` pulses to the peer that supplied the data, and only in the cycle after the home's completion.
- R8: If the home completes with `home_wait` set and no data has arrived, the block ignores data from every node except `home_wait_node`. When that node's data arrives, the block installs the line and pulses `dack_valid` to that node one cycle later.
- R9: If the home completes with `home_fwd` set, `fwd_valid` pulses to `home_fwd_node` one cycle after `use_done`, and never before it. The line then becomes I after a read for ownership, or S after a shared read.
- R10: After reset, `req_ready` = 1, `line_state` = I, and `global_obs` = 0 and `data_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | New request from the local cache |
| req_rfo | input | 1 | 1 = read for ownership, 0 = shared read |
| req_ready | output | 1 | Tracker idle; a request can be accepted |
| snp_valid | output | 1 | Broadcast the request to all nodes |
| snp_rfo | output | 1 | Type of the broadcast request |
| resp_valid | input | 1 | Snoop response or forwarded data arriving |
| resp_src | input | NID_W | Node that sent the response |
| resp_kind | input | 2 | 0 invalid ack, 1 shared ack, 2 conflict |
| resp_data | input | 1 | The response carries the line data |
| peer_req_valid | input | 1 | Same-line request from another node observed |
| peer_req_src | input | NID_W | Node that issued that request |
| ph2_valid | output | 1 | Second-phase message to the home |
| ph2_cancel | output | 1 | 1 = cancel, 0 = read |
| ph2_conflicts | output | NODES | Conflicting node bitmap |
| home_valid | input | 1 | Completion message from the home |
| home_data | input | 1 | Completion carries the line data |
| home_fwd | input | 1 | Forward order present |
| home_fwd_node | input | NID_W | Node to forward the line to |
| home_wait | input | 1 | Wait order present |
| home_wait_node | input | NID_W | Node that will supply the data |
| use_done | input | 1 | Local consumer has finished with the line |
| dack_valid | output | 1 | Data acknowledgement to the supplier |
| dack_dst | output | NID_W | Node that receives the acknowledgement |
| fwd_valid | output | 1 | Send the line to the next node |
| fwd_dst | output | NID_W | Node the line is forwarded to |
| data_ready | output | 1 | Line data is usable locally |
| global_obs | output | 1 | Transaction globally observed |
| line_state | output | 3 | Installed line state, I/S/E/F/M = 0..4 |

## Verification
The hardest situation to reach is the losing node in a conflict. To get there, the bench first injects a conflict response, so that the tracker sends a read carrying that node's bit. The home then completes with a wait order and no data. Next the bench offers data from the wrong node, and the tracker must ignore it. Finally the named node sends the data, which must produce a late acknowledgement to that node. The forwarding path is reached through a winner that gets a forward order: the bench holds back `use_done` for several cycles, and the scoreboard must see no forward pulse until it is given.

// File: rtl/sst_tracker.sv
module sst_tracker #(
  parameter int NODES   = 4,
  parameter int SELF_ID = 0,
  parameter int HOME_ID = NODES - 1,
  localparam int NID_W  = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_rfo,
  output logic             req_ready,
  output logic             snp_valid,
  output logic             snp_rfo,
  input  logic             resp_valid,
  input  logic [NID_W-1:0] resp_src,
  input  logic [1:0]       resp_kind,
  input  logic             resp_data,
  input  logic             peer_req_valid,
  input  logic [NID_W-1:0] peer_req_src,
  output logic             ph2_valid,
  output logic             ph2_cancel,
  output logic [NODES-1:0] ph2_conflicts,
  input  logic             home_valid,
  input  logic             home_data,
  input  logic             home_fwd,
  input  logic [NID_W-1:0] home_fwd_node,
  input  logic             home_wait,
  input  logic [NID_W-1:0] home_wait_node,
  input  logic             use_done,
  output logic             dack_valid,
  output logic [NID_W-1:0] dack_dst,
  output logic             fwd_valid,
  output logic [NID_W-1:0] fwd_dst,
  output logic             data_ready,
  output logic             global_obs,
  output logic [2:0]       line_state
);
  localparam logic [NODES-1:0] ONE  = {{(NODES-1){1'b0}}, 1'b1};
  localparam logic [NODES-1:0] NEED = ~(ONE << SELF_ID) & ~(ONE << HOME_ID);
  localparam logic [2:0] LS_I = 3'd0, LS_S = 3'd1, LS_E = 3'd2, LS_F = 3'd3, LS_M = 3'd4;
  localparam logic [1:0] K_SACK = 2'd1, K_CNFL = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_SNOOP, S_PH2, S_HOME, S_WAITD, S_FWD} st_t;
  st_t st;

  logic             rfo_q, shared_q, have_data, fwd_pend;
  logic [NODES-1:0] got, cnfl;
  logic [NID_W-1:0] supplier, fwd_node, wait_node;
  logic             snp_q, dack_q, fwd_q, rdy_q, go_q;
  logic [NID_W-1:0] dack_dst_q, fwd_dst_q;
  logic [2:0]       ls_q;

  wire [NODES-1:0] src_bit  = ONE << resp_src;
  wire [NODES-1:0] peer_bit = ONE << peer_req_src;
  wire             resp_hit = resp_valid && ((NEED & src_bit & ~got) != '0);
  wire [NODES-1:0] got_nx   = resp_hit ? (got | src_bit) : got;
  wire             cnfl_rsp = resp_hit && (resp_kind == K_CNFL);

  assign req_ready     = (st == S_IDLE);
  assign snp_valid     = snp_q;
  assign snp_rfo       = rfo_q;
  assign ph2_valid     = (st == S_PH2);
  assign ph2_cancel    = have_data;
  assign ph2_conflicts = cnfl;
  assign dack_valid    = dack_q;
  assign dack_dst      = dack_dst_q;
  assign fwd_valid     = fwd_q;
  assign fwd_dst       = fwd_dst_q;
  assign data_ready    = rdy_q;
  assign global_obs    = go_q;
  assign line_state    = ls_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rfo_q <= 1'b0; shared_q <= 1'b0; have_data <= 1'b0; fwd_pend <= 1'b0;
      got <= '0; cnfl <= '0;
      supplier <= '0; fwd_node <= '0; wait_node <= '0;
      snp_q <= 1'b0; dack_q <= 1'b0; fwd_q <= 1'b0;
      dack_dst_q <= '0; fwd_dst_q <= '0;
      rdy_q <= 1'b0; go_q <= 1'b0; ls_q <= LS_I;
    end else begin
      snp_q  <= 1'b0;
      dack_q <= 1'b0;
      fwd_q  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st <= S_SNOOP;
          rfo_q <= req_rfo;
          got <= '0; cnfl <= '0;
          shared_q <= 1'b0; have_data <= 1'b0; fwd_pend <= 1'b0;
          snp_q <= 1'b1;
          go_q <= 1'b0; rdy_q <= 1'b0; ls_q <= LS_I;
        end
        S_SNOOP: begin
          got  <= got_nx;
          cnfl <= cnfl | (cnfl_rsp ? src_bit : '0) | (peer_req_valid ? peer_bit : '0);
          if (resp_hit && resp_kind == K_SACK) shared_q <= 1'b1;
          if (resp_hit && resp_data && !have_data) begin
            have_data <= 1'b1;
            supplier  <= resp_src;
            rdy_q     <= 1'b1;
            ls_q      <= rfo_q ? LS_M : LS_F;
          end
          if (got_nx == NEED) st <= S_PH2;
        end
        S_PH2: st <= S_HOME;
        S_HOME: if (home_valid) begin
          go_q      <= 1'b1;
          fwd_pend  <= home_fwd;
          fwd_node  <= home_fwd_node;
          wait_node <= home_wait_node;
          if (have_data) begin
            dack_q     <= 1'b1;
            dack_dst_q <= supplier;
          end else if (home_data) begin
            rdy_q <= 1'b1;
            ls_q  <= rfo_q ? LS_M : (shared_q ? LS_F : LS_E);
          end
          if (home_wait && !have_data && !home_data) st <= S_WAITD;
          else if (home_fwd)                        st <= S_FWD;
          else                                      st <= S_IDLE;
        end
        S_WAITD: if (resp_valid && resp_data && resp_src == wait_node) begin
          rdy_q      <= 1'b1;
          ls_q       <= rfo_q ? LS_M : LS_F;
          dack_q     <= 1'b1;
          dack_dst_q <= resp_src;
          st         <= fwd_pend ? S_FWD : S_IDLE;
        end
        S_FWD: if (use_done) begin
          fwd_q     <= 1'b1;
          fwd_dst_q <= fwd_node;
          ls_q      <= rfo_q ? LS_I : LS_S;
          if (rfo_q) rdy_q <= 1'b0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sst_tracker_chk.sv
module sst_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic snp_valid,
  input logic ph2_valid,
  input logic home_valid,
  input logic dack_valid,
  input logic fwd_valid,
  input logic use_done,
  input logic global_obs
);
  p_busy_no_snp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> !snp_valid);
  p_snp_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> $past(req_valid && req_ready));
  p_ph2_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ph2_valid |=> !ph2_valid);
  p_go_from_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(global_obs) |-> $past(home_valid));
  p_no_go_in_ph2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ph2_valid |-> !global_obs);
  p_dack_after_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dack_valid |-> global_obs);
  p_fwd_after_use_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(use_done));
endmodule

bind sst_tracker sst_tracker_chk u_chk (.*);

// File: tb/tb_sst_tracker.sv
module tb_sst_tracker;
  localparam int NODES = 4;
  localparam int NW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_rfo = 0, req_ready, snp_valid, snp_rfo;
  logic resp_valid = 0, resp_data = 0; logic [NW-1:0] resp_src = 0; logic [1:0] resp_kind = 0;
  logic peer_req_valid = 0; logic [NW-1:0] peer_req_src = 0;
  logic ph2_valid, ph2_cancel; logic [NODES-1:0] ph2_conflicts;
  logic home_valid = 0, home_data = 0, home_fwd = 0, home_wait = 0;
  logic [NW-1:0] home_fwd_node = 0, home_wait_node = 0;
  logic use_done = 0, dack_valid, fwd_valid, data_ready, global_obs;
  logic [NW-1:0] dack_dst, fwd_dst; logic [2:0] line_state;

  sst_tracker #(.NODES(NODES), .SELF_ID(0), .HOME_ID(3)) dut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  logic [11:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp); end
  endtask

  function automatic string tag_of(input logic [3:0] k);
    case (k)
      4'd1: return "R2 broadcast";
      4'd2: return "R4 phase2";
      4'd3: return "R7 dack";
      default: return "R9 forward";
    endcase
  endfunction

  task automatic seen(input logic [11:0] it);
    logic [11:0] e;
    if (exp_q.size() == 0) begin
      total++; bad++;
      $display("FAIL %s unexpected: actual=%0h expected=none", tag_of(it[11:8]), it);
    end else begin
      e = exp_q.pop_front();
      chk(e == it, tag_of(e[11:8]), int'(it), int'(e));
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (snp_valid)  seen({4'd1, 7'd0, snp_rfo});
    if (ph2_valid)  seen({4'd2, 3'd0, ph2_cancel, ph2_conflicts});
    if (dack_valid) seen({4'd3, 6'd0, dack_dst});
    if (fwd_valid)  seen({4'd4, 6'd0, fwd_dst});
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_req(input logic rfo);
    req_valid = 1; req_rfo = rfo; tick(); req_valid = 0;
  endtask
  task automatic do_resp(input logic [NW-1:0] s, input logic [1:0] k, input logic d);
    resp_valid = 1; resp_src = s; resp_kind = k; resp_data = d; tick(); resp_valid = 0; resp_data = 0;
  endtask
  task automatic do_peer(input logic [NW-1:0] s);
    peer_req_valid = 1; peer_req_src = s; tick(); peer_req_valid = 0;
  endtask
  task automatic do_home(input logic d, input logic f, input logic [NW-1:0] fn,
                         input logic w, input logic [NW-1:0] wn);
    tick();
    home_valid = 1; home_data = d; home_fwd = f; home_fwd_node = fn; home_wait = w; home_wait_node = wn;
    tick();
    home_valid = 0; home_data = 0; home_fwd = 0; home_wait = 0;
  endtask
  task automatic do_use();
    use_done = 1; tick(); use_done = 0;
  endtask
  task automatic push(input logic [3:0] k, input logic [7:0] v);
    exp_q.push_back({k, v});
  endtask

  bit finished = 0;
  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(2); rst_n = 1; tick();
    chk(req_ready == 1, "R10 ready", req_ready, 1);
    chk(line_state == 0, "R10 state", line_state, 0);
    chk(global_obs == 0 && data_ready == 0, "R10 flags", {global_obs, data_ready}, 0);

    // R3: shared read, uncached; home and duplicate responses ignored
    push(1, 0); do_req(0);
    do_resp(3, 0, 0); do_resp(1, 0, 0); do_resp(1, 0, 0); tick(3);
    chk(req_ready == 0, "R1 busy", req_ready, 0);
    push(2, 8'h00); do_resp(2, 0, 0);
    chk(global_obs == 0, "R6 no go before home", global_obs, 0);
    do_home(1, 0, 0, 0, 0);
    chk(global_obs == 1, "R6 go", global_obs, 1);
    chk(line_state == 2, "R5 all invalid acks -> E", line_state, 2);
    chk(data_ready == 1, "R6 home data ready", data_ready, 1);
    tick();
    chk(req_ready == 1, "R1 idle again", req_ready, 1);

    // R5: shared ack then home data -> F
    push(1, 0); do_req(0);
    do_resp(1, 1, 0); push(2, 8'h00); do_resp(2, 0, 0);
    do_home(1, 0, 0, 0, 0);
    chk(line_state == 3, "R5 shared ack -> F", line_state, 3);

    // R6/R7: data from forwarding peer, dack only after home
    push(1, 0); do_req(0);
    do_resp(1, 0, 0); push(2, 8'h10); do_resp(2, 0, 1);
    chk(data_ready == 1 && global_obs == 0, "R6 early use", {data_ready, global_obs}, 2);
    chk(line_state == 3, "R5 peer data -> F", line_state, 3);
    tick(3);
    push(3, 2); do_home(0, 0, 0, 0, 0);
    chk(global_obs == 1, "R6 go after ack", global_obs, 1);

    // R4/R9: ownership winner with observed peer request, forward order
    push(1, 1); do_req(1);
    do_resp(1, 0, 1); do_peer(2); push(2, 8'h14); do_resp(2, 0, 0);
    chk(line_state == 4, "R5 rfo -> M", line_state, 4);
    push(3, 1); do_home(0, 1, 2, 0, 0);
    tick(3);
    chk(line_state == 4, "R9 held until use", line_state, 4);
    push(4, 2); do_use(); tick();
    chk(line_state == 0, "R9 rfo forward -> I", line_state, 0);
    chk(data_ready == 0, "R9 data dropped", data_ready, 0);

    // R8: ownership loser, wait order
    do_peer(1); tick();
    push(1, 1); do_req(1);
    do_resp(1, 2, 0); push(2, 8'h02); do_resp(2, 0, 0);
    do_home(0, 0, 0, 1, 1);
    chk(global_obs == 1 && data_ready == 0, "R8 wait go", {global_obs, data_ready}, 2);
    do_resp(2, 0, 1); tick();
    chk(data_ready == 0, "R8 wrong node ignored", data_ready, 0);
    push(3, 1); do_resp(1, 0, 1);
    chk(data_ready == 1 && line_state == 4, "R8 named data", {data_ready, line_state}, 12);
    tick();

    // R1/R9: request while busy ignored; shared read forwarded -> S
    push(1, 0); do_req(0); do_req(1);
    chk(req_ready == 0, "R1 refused", req_ready, 0);
    do_resp(1, 0, 0); push(2, 8'h00); do_resp(2, 0, 0);
    do_home(1, 1, 1, 0, 0);
    chk(line_state == 2, "R5 E before forward", line_state, 2);
    push(4, 1); do_use(); tick();
    chk(line_state == 1, "R9 shared forward -> S", line_state, 1);

    tick(4);
    chk(exp_q.size() == 0, "R3 all expected seen", exp_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule